// File: doc/BRIEF.md
# Single-Cycle 16-Bit Word-Addressed RISC Core

This block is a small processor core that completes one whole instruction in every clock cycle. Program and data sit in two separate word-addressed arrays inside the block. In one cycle the core takes the instruction word at the current program counter and decodes it. It reads up to two operands from an eight-entry register bank and computes a result. If the instruction asks for it, the core then reads or writes the data array. The cycle ends with the write-back and the next program-counter value, both taken at the rising clock edge.

While reset is held, a load port fills the two arrays. The program counter stays at zero during reset, and the core starts fetching at word 0 on the first edge after reset is released. Every store the core makes is also shown on a store-observation bus. That bus is the way a test or a neighbouring block sees what the program computed. By software convention register 6 serves as the stack pointer and the stack grows toward lower data addresses. Register 7 takes the return address of the relative call.

Top module: `wk16_core`

## Requirements
- R1: Reset is synchronous. While `rst` is high, each rising edge leaves `pc_o` at 0, the core makes no stores and it writes no registers. The first edge after release executes the instruction at word 0.
- R2: Register 0 always reads as 0, and every write aimed at it is dropped.
- R3: Three register-to-register opcodes share one layout: opcode in bits [15:11], rs1 in [10:8], rs2 in [7:5], rd in [4:2] and a sub-function in [1:0]. Opcode 0 gives add/sub/and/or for sub-function 0/1/2/3. Opcode 1 gives xor for sub-function 0.
- R4: Opcode 1 with sub-function 1, 2 or 3 gives a logical left shift, a logical right shift or an arithmetic right shift of rs1. The shift amount is the low 4 bits of rs2.
- R5: Opcode 2 with sub-function 0 gives a signed less-than and sub-function 1 an unsigned less-than. Either one writes 1 or 0 into rd. Sub-functions 2 and 3 write nothing.
- R6: Immediate forms take rs1 from [10:8], rd from [7:5] and a 5-bit field from [4:0], which is sign-extended to 16 bits. The opcodes are 3 add, 4 and, 5 or, 6 xor, 7 signed less-than, 8 left shift, 9 logical right shift and 10 arithmetic right shift. A shift uses the low 4 bits of the immediate.
- R7: Opcode 11 loads rd with {bits[10:8], bits[4:0]} placed in bits [15:8] and zeros in bits [7:0].
- R8: Opcode 12 loads rd from data word rs1 plus the sign-extended [4:0] field. Opcode 13 stores rs2 (field [7:5]) to data word rs1 plus the sign-extended field {[4:2],[1:0]}. In the same cycle the store raises `st_en_o` and shows the full 16-bit address and the data.
- R9: Opcode 14 branches when rs1 equals rs2 and opcode 15 when they differ. The target is PC plus the sign-extended 5-bit split field. A branch that is not taken goes to PC+1.
- R10: Opcode 16 jumps to PC plus the sign-extended 11-bit field [10:0]. Opcode 17 does the same and also writes PC+1 into register 7.
- R11: Opcode 18 (immediate layout) writes PC+1 into rd and jumps to rs1 plus the sign-extended [4:0] field. The target is formed from rs1 as it was before the write.
- R12: Opcodes 19 to 31 change nothing except the program counter, which moves to PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load-port write strobe for the internal arrays |
| ld_dmem | input | 1 | Load target: 0 selects the program array, 1 the data array |
| ld_addr | input | 16 | Word address for the load port |
| ld_data | input | 16 | Word written through the load port |
| pc_o | output | 16 | Current program counter (word address of the instruction in flight) |
| st_en_o | output | 1 | High in a cycle whose instruction stores to data memory |
| st_addr_o | output | 16 | Word address of that store |
| st_data_o | output | 16 | Data of that store |

## Verification
Each operation group runs on one pair of operands. One operand has its top bit set and the other does not. So a signed/unsigned mix-up in a comparison, a logical shift used where an arithmetic one is needed, or a missing sign extension gives a visibly wrong stored word. The shift amounts 0, 4 and 15, plus a register whose amount bits are clear while higher bits are set, check that only four amount bits are used. Control flow is tried with taken and not-taken branches, a backward loop counted to three, and forward and backward jumps. Skipped instructions are stores, so a wrong target shows up as an extra store or a missing one. Register 0 used as a target and as a base, a stack pointer decremented through zero, and unused opcodes carrying register fields check that the bank is changed only where it should be.

// File: rtl/wk16_pkg.sv
package wk16_pkg;

   localparam int unsigned ISA_W   = 16;
   localparam int unsigned RIDX_W  = 3;
   localparam int unsigned OPC_W   = 5;
   localparam int unsigned LINK_RG = 7;

   typedef enum logic [4:0] {
      OP_RA   = 5'd0,
      OP_RB   = 5'd1,
      OP_RC   = 5'd2,
      OP_ADDI = 5'd3,
      OP_ANDI = 5'd4,
      OP_ORI  = 5'd5,
      OP_XORI = 5'd6,
      OP_SLTI = 5'd7,
      OP_SLLI = 5'd8,
      OP_SRLI = 5'd9,
      OP_SRAI = 5'd10,
      OP_LUI  = 5'd11,
      OP_LW   = 5'd12,
      OP_SW   = 5'd13,
      OP_BEQ  = 5'd14,
      OP_BNE  = 5'd15,
      OP_J    = 5'd16,
      OP_JAL  = 5'd17,
      OP_JALR = 5'd18
   } opcode_e;

   typedef enum logic [3:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
      ALU_SLL, ALU_SRL, ALU_SRA, ALU_SLT, ALU_SLTU, ALU_PASSB
   } alu_op_e;

   typedef enum logic [1:0] {
      NXT_SEQ, NXT_BR, NXT_JREL, NXT_JREG
   } pc_sel_e;

   typedef enum logic [1:0] {
      WB_ALU, WB_MEM, WB_LINK
   } wb_sel_e;

   typedef struct packed {
      alu_op_e             alu_op;
      logic                b_is_imm;
      logic                reg_we;
      logic                mem_we;
      wb_sel_e             wb_sel;
      pc_sel_e             pc_sel;
      logic                br_on_ne;
      logic [RIDX_W-1:0]   rd;
   } ctrl_t;

endpackage

// File: rtl/wk16_decode.sv
module wk16_decode
   import wk16_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [ISA_W-1:0]  instr,
   output ctrl_t             ctrl,
   output logic [W-1:0]      imm,
   output logic [RIDX_W-1:0] rs1_a,
   output logic [RIDX_W-1:0] rs2_a
);

   logic [OPC_W-1:0] opc;
   logic [1:0]       func;
   logic [4:0]       f_imm;
   logic [4:0]       f_split;
   logic [10:0]      f_jmp;
   logic [W-1:0]     sx_imm;
   logic [W-1:0]     sx_split;
   logic [W-1:0]     sx_jmp;
   logic [W-1:0]     up_imm;

   assign opc     = instr[15:11];
   assign func    = instr[1:0];
   assign f_imm   = instr[4:0];
   assign f_split = {instr[4:2], instr[1:0]};
   assign f_jmp   = instr[10:0];
   assign rs1_a   = instr[10:8];
   assign rs2_a   = instr[7:5];

   assign sx_imm   = {{(W-5){f_imm[4]}}, f_imm};
   assign sx_split = {{(W-5){f_split[4]}}, f_split};
   assign sx_jmp   = {{(W-11){f_jmp[10]}}, f_jmp};
   assign up_imm   = {instr[10:8], instr[4:0], {(W-8){1'b0}}};

   always_comb begin
      ctrl          = '0;
      ctrl.alu_op   = ALU_ADD;
      ctrl.wb_sel   = WB_ALU;
      ctrl.pc_sel   = NXT_SEQ;
      ctrl.rd       = instr[4:2];
      imm           = '0;
      case (opc)
         OP_RA: begin
            ctrl.reg_we = 1'b1;
            case (func)
               2'd0:    ctrl.alu_op = ALU_ADD;
               2'd1:    ctrl.alu_op = ALU_SUB;
               2'd2:    ctrl.alu_op = ALU_AND;
               default: ctrl.alu_op = ALU_OR;
            endcase
         end
         OP_RB: begin
            ctrl.reg_we = 1'b1;
            case (func)
               2'd0:    ctrl.alu_op = ALU_XOR;
               2'd1:    ctrl.alu_op = ALU_SLL;
               2'd2:    ctrl.alu_op = ALU_SRL;
               default: ctrl.alu_op = ALU_SRA;
            endcase
         end
         OP_RC: begin
            ctrl.reg_we = (func[1] == 1'b0);
            ctrl.alu_op = func[0] ? ALU_SLTU : ALU_SLT;
         end
         OP_ADDI, OP_ANDI, OP_ORI, OP_XORI,
         OP_SLTI, OP_SLLI, OP_SRLI, OP_SRAI: begin
            ctrl.reg_we   = 1'b1;
            ctrl.b_is_imm = 1'b1;
            ctrl.rd       = instr[7:5];
            imm           = sx_imm;
            case (opc)
               OP_ANDI: ctrl.alu_op = ALU_AND;
               OP_ORI:  ctrl.alu_op = ALU_OR;
               OP_XORI: ctrl.alu_op = ALU_XOR;
               OP_SLTI: ctrl.alu_op = ALU_SLT;
               OP_SLLI: ctrl.alu_op = ALU_SLL;
               OP_SRLI: ctrl.alu_op = ALU_SRL;
               OP_SRAI: ctrl.alu_op = ALU_SRA;
               default: ctrl.alu_op = ALU_ADD;
            endcase
         end
         OP_LUI: begin
            ctrl.reg_we   = 1'b1;
            ctrl.b_is_imm = 1'b1;
            ctrl.rd       = instr[7:5];
            ctrl.alu_op   = ALU_PASSB;
            imm           = up_imm;
         end
         OP_LW: begin
            ctrl.reg_we   = 1'b1;
            ctrl.b_is_imm = 1'b1;
            ctrl.rd       = instr[7:5];
            ctrl.wb_sel   = WB_MEM;
            imm           = sx_imm;
         end
         OP_SW: begin
            ctrl.mem_we   = 1'b1;
            ctrl.b_is_imm = 1'b1;
            imm           = sx_split;
         end
         OP_BEQ, OP_BNE: begin
            ctrl.alu_op   = ALU_SUB;
            ctrl.pc_sel   = NXT_BR;
            ctrl.br_on_ne = (opc == OP_BNE);
            imm           = sx_split;
         end
         OP_J: begin
            ctrl.pc_sel = NXT_JREL;
            imm         = sx_jmp;
         end
         OP_JAL: begin
            ctrl.pc_sel = NXT_JREL;
            ctrl.reg_we = 1'b1;
            ctrl.rd     = RIDX_W'(LINK_RG);
            ctrl.wb_sel = WB_LINK;
            imm         = sx_jmp;
         end
         OP_JALR: begin
            ctrl.pc_sel   = NXT_JREG;
            ctrl.reg_we   = 1'b1;
            ctrl.b_is_imm = 1'b1;
            ctrl.rd       = instr[7:5];
            ctrl.wb_sel   = WB_LINK;
            imm           = sx_imm;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/wk16_regfile.sv
module wk16_regfile #(
   parameter int unsigned W    = 16,
   parameter int unsigned NREG = 8
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] wa,
   input  logic [W-1:0]            wd,
   input  logic [$clog2(NREG)-1:0] ra1,
   input  logic [$clog2(NREG)-1:0] ra2,
   output logic [W-1:0]            rd1,
   output logic [W-1:0]            rd2
);

   localparam int unsigned AW = $clog2(NREG);

   logic [W-1:0] bank [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_ent
      if (g == 0) begin : g_zero
         assign bank[g] = '0;
      end else begin : g_store
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (we && (wa == AW'(g))) q <= wd;
         end
         assign bank[g] = q;
      end
   end

   assign rd1 = bank[ra1];
   assign rd2 = bank[ra2];

endmodule

// File: rtl/wk16_alu.sv
module wk16_alu
   import wk16_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);

   localparam int unsigned SHW = $clog2(W);

   logic [SHW-1:0] sh;
   assign sh = b[SHW-1:0];

   always_comb begin
      y = '0;
      case (op)
         ALU_ADD:   y = a + b;
         ALU_SUB:   y = a - b;
         ALU_AND:   y = a & b;
         ALU_OR:    y = a | b;
         ALU_XOR:   y = a ^ b;
         ALU_SLL:   y = a << sh;
         ALU_SRL:   y = a >> sh;
         ALU_SRA:   y = $unsigned($signed(a) >>> sh);
         ALU_SLT:   y[0] = ($signed(a) < $signed(b));
         ALU_SLTU:  y[0] = (a < b);
         ALU_PASSB: y = b;
         default:   y = '0;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/wk16_pcgen.sv
module wk16_pcgen
   import wk16_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] pc,
   input  logic [W-1:0] imm,
   input  logic [W-1:0] reg_tgt,
   input  logic         alu_zero,
   input  pc_sel_e      pc_sel,
   input  logic         br_on_ne,
   output logic [W-1:0] pc_inc,
   output logic [W-1:0] pc_next
);

   logic [W-1:0] pc_rel;
   logic         br_take;

   assign pc_inc  = pc + W'(1);
   assign pc_rel  = pc + imm;
   assign br_take = alu_zero ^ br_on_ne;

   always_comb begin
      case (pc_sel)
         NXT_BR:   pc_next = br_take ? pc_rel : pc_inc;
         NXT_JREL: pc_next = pc_rel;
         NXT_JREG: pc_next = reg_tgt;
         default:  pc_next = pc_inc;
      endcase
   end

endmodule

// File: rtl/wk16_core.sv
module wk16_core
   import wk16_pkg::*;
#(
   parameter int unsigned XLEN       = 16,
   parameter int unsigned NREGS      = 8,
   parameter int unsigned IMEM_WORDS = 64,
   parameter int unsigned DMEM_WORDS = 64
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ld_en,
   input  logic            ld_dmem,
   input  logic [XLEN-1:0] ld_addr,
   input  logic [XLEN-1:0] ld_data,
   output logic [XLEN-1:0] pc_o,
   output logic            st_en_o,
   output logic [XLEN-1:0] st_addr_o,
   output logic [XLEN-1:0] st_data_o
);

   localparam int unsigned IAW = $clog2(IMEM_WORDS);
   localparam int unsigned DAW = $clog2(DMEM_WORDS);

   if (XLEN != ISA_W) begin : g_bad_xlen
      $error("wk16_core: XLEN must equal the 16-bit instruction width");
   end
   if (NREGS != (1 << RIDX_W)) begin : g_bad_nregs
      $error("wk16_core: NREGS must match the 3-bit register fields");
   end
   if ((IMEM_WORDS < 2) || (IMEM_WORDS != (1 << IAW)) || (IAW > XLEN)) begin : g_bad_imem
      $error("wk16_core: IMEM_WORDS must be a power of two within the address range");
   end
   if ((DMEM_WORDS < 2) || (DMEM_WORDS != (1 << DAW)) || (DAW > XLEN)) begin : g_bad_dmem
      $error("wk16_core: DMEM_WORDS must be a power of two within the address range");
   end

   logic [XLEN-1:0]   pc_q;
   logic [XLEN-1:0]   pc_next;
   logic [XLEN-1:0]   pc_inc;
   logic [XLEN-1:0]   instr;
   ctrl_t             ctrl;
   logic [XLEN-1:0]   imm;
   logic [RIDX_W-1:0] rs1_a;
   logic [RIDX_W-1:0] rs2_a;
   logic [XLEN-1:0]   rs1_val;
   logic [XLEN-1:0]   rs2_val;
   logic [XLEN-1:0]   b_opnd;
   logic [XLEN-1:0]   alu_y;
   logic              alu_zero;
   logic [XLEN-1:0]   ld_val;
   logic [XLEN-1:0]   wb_val;
   logic              rf_we;
   logic [RIDX_W-1:0] rf_wa;
   logic              st_en;

   // program array: filled through the load port, read combinationally
   logic [XLEN-1:0] imem [IMEM_WORDS];
   always_ff @(posedge clk) begin
      if (ld_en && !ld_dmem) imem[ld_addr[IAW-1:0]] <= ld_data;
   end
   assign instr = imem[pc_q[IAW-1:0]];

   wk16_decode #(.W(XLEN)) u_dec (
      .instr (instr),
      .ctrl  (ctrl),
      .imm   (imm),
      .rs1_a (rs1_a),
      .rs2_a (rs2_a)
   );

   assign rf_we = ctrl.reg_we && !rst;
   assign rf_wa = ctrl.rd;

   wk16_regfile #(.W(XLEN), .NREG(NREGS)) u_rf (
      .clk (clk),
      .we  (rf_we),
      .wa  (rf_wa),
      .wd  (wb_val),
      .ra1 (rs1_a),
      .ra2 (rs2_a),
      .rd1 (rs1_val),
      .rd2 (rs2_val)
   );

   assign b_opnd = ctrl.b_is_imm ? imm : rs2_val;

   wk16_alu #(.W(XLEN)) u_alu (
      .a    (rs1_val),
      .b    (b_opnd),
      .op   (ctrl.alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // data array: load port has priority, core store otherwise
   logic [XLEN-1:0] dmem [DMEM_WORDS];
   assign st_en = ctrl.mem_we && !rst;
   always_ff @(posedge clk) begin
      if (ld_en && ld_dmem) dmem[ld_addr[DAW-1:0]] <= ld_data;
      else if (st_en)       dmem[alu_y[DAW-1:0]]   <= rs2_val;
   end
   assign ld_val = dmem[alu_y[DAW-1:0]];

   wk16_pcgen #(.W(XLEN)) u_pcg (
      .pc       (pc_q),
      .imm      (imm),
      .reg_tgt  (alu_y),
      .alu_zero (alu_zero),
      .pc_sel   (ctrl.pc_sel),
      .br_on_ne (ctrl.br_on_ne),
      .pc_inc   (pc_inc),
      .pc_next  (pc_next)
   );

   always_comb begin
      case (ctrl.wb_sel)
         WB_MEM:  wb_val = ld_val;
         WB_LINK: wb_val = pc_inc;
         default: wb_val = alu_y;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   assign pc_o      = pc_q;
   assign st_en_o   = st_en;
   assign st_addr_o = alu_y;
   assign st_data_o = rs2_val;

endmodule

// File: rtl/wk16_core_chk.sv
module wk16_core_chk
   import wk16_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic [W-1:0]      pc,
   input logic [W-1:0]      instr,
   input logic [W-1:0]      imm,
   input logic [RIDX_W-1:0] rs1_a,
   input logic [W-1:0]      rs1_val,
   input logic [W-1:0]      rs2_val,
   input logic              rf_we,
   input logic [RIDX_W-1:0] rf_wa,
   input logic [W-1:0]      rf_wd,
   input logic              st_en,
   input logic [W-1:0]      st_addr
);

   logic [OPC_W-1:0] opc;
   assign opc = instr[15:11];

   // R1: reset returns the program counter to zero on the next edge
   p_pc_clear_r1: assert property (@(posedge clk) rst |=> (pc == '0));

   // R1: nothing is written while reset is high
   p_quiet_reset_r1: assert property (@(posedge clk) rst |-> (!rf_we && !st_en));

   // R2: register 0 reads as zero
   p_zero_read_r2: assert property (@(posedge clk) disable iff (rst)
      (rs1_a == '0) |-> (rs1_val == '0));

   // R8: store address is base plus displacement
   p_st_addr_r8: assert property (@(posedge clk) disable iff (rst)
      st_en |-> (st_addr == rs1_val + imm));

   // R9: equal operands take the equality branch
   p_beq_take_r9: assert property (@(posedge clk) disable iff (rst)
      ((opc == OP_BEQ) && (rs1_val == rs2_val)) |=> (pc == $past(pc) + $past(imm)));

   // R10: relative call links PC+1 into register 7
   p_link_r10: assert property (@(posedge clk) disable iff (rst)
      (opc == OP_JAL) |-> (rf_we && (rf_wa == RIDX_W'(LINK_RG)) && (rf_wd == pc + W'(1))));

   // R12: unused opcodes write nothing
   p_unused_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      (opc > OP_JALR) |-> (!rf_we && !st_en));

   // R12: unused opcodes step to the next word
   p_unused_step_r12: assert property (@(posedge clk) disable iff (rst)
      (opc > OP_JALR) |=> (pc == $past(pc) + W'(1)));

endmodule

bind wk16_core wk16_core_chk #(.W(XLEN)) i_chk (
   .clk     (clk),
   .rst     (rst),
   .pc      (pc_q),
   .instr   (instr),
   .imm     (imm),
   .rs1_a   (rs1_a),
   .rs1_val (rs1_val),
   .rs2_val (rs2_val),
   .rf_we   (rf_we),
   .rf_wa   (rf_wa),
   .rf_wd   (wb_val),
   .st_en   (st_en_o),
   .st_addr (st_addr_o)
);

// File: tb/test_wk16_core.sv
`timescale 1ns/1ps
module test_wk16_core;

   localparam int O_RA = 0, O_RB = 1, O_RC = 2, O_ADDI = 3, O_ANDI = 4, O_ORI = 5;
   localparam int O_XORI = 6, O_SLTI = 7, O_SLLI = 8, O_SRLI = 9, O_SRAI = 10;
   localparam int O_LUI = 11, O_LW = 12, O_SW = 13, O_BEQ = 14, O_BNE = 15;
   localparam int O_J = 16, O_JAL = 17, O_JALR = 18;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_en = 1'b0;
   logic        ld_dmem = 1'b0;
   logic [15:0] ld_addr = '0;
   logic [15:0] ld_data = '0;
   logic [15:0] pc_o;
   logic        st_en_o;
   logic [15:0] st_addr_o;
   logic [15:0] st_data_o;

   int checks = 0;
   int fails  = 0;
   int pa     = 0;

   logic [15:0] lg_a [64];
   logic [15:0] lg_d [64];
   int          lg_n = 0;

   wk16_core i_wk16_core (
      .clk       (clk),
      .rst       (rst),
      .ld_en     (ld_en),
      .ld_dmem   (ld_dmem),
      .ld_addr   (ld_addr),
      .ld_data   (ld_data),
      .pc_o      (pc_o),
      .st_en_o   (st_en_o),
      .st_addr_o (st_addr_o),
      .st_data_o (st_data_o)
   );

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      if (!rst && st_en_o && lg_n < 64) begin
         lg_a[lg_n] = st_addr_o;
         lg_d[lg_n] = st_data_o;
         lg_n++;
      end
   end

   function automatic logic [15:0] enc_r(int op, int s1, int s2, int d, int f);
      return {op[4:0], s1[2:0], s2[2:0], d[2:0], f[1:0]};
   endfunction
   function automatic logic [15:0] enc_i(int op, int s1, int d, int im);
      return {op[4:0], s1[2:0], d[2:0], im[4:0]};
   endfunction
   function automatic logic [15:0] enc_s(int op, int s1, int s2, int im);
      return {op[4:0], s1[2:0], s2[2:0], im[4:0]};
   endfunction
   function automatic logic [15:0] enc_j(int op, int im);
      return {op[4:0], im[10:0]};
   endfunction
   function automatic logic [15:0] enc_lui(int d, int v);
      return {5'd11, v[7:5], d[2:0], v[4:0]};
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_st(string tag, int idx, logic [15:0] ea, logic [15:0] ed);
      checks++;
      if (idx >= lg_n) begin
         fails++;
         $display("FAIL %s store#%0d missing actual_count=%0d expected>%0d", tag, idx, lg_n, idx);
      end else if (lg_a[idx] !== ea || lg_d[idx] !== ed) begin
         fails++;
         $display("FAIL %s store#%0d actual=%h:%h expected=%h:%h",
                  tag, idx, lg_a[idx], lg_d[idx], ea, ed);
      end
   endtask

   task automatic begin_test();
      rst   = 1'b1;
      ld_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      lg_n = 0;
      pa   = 0;
   endtask

   task automatic put(logic sel, int a, logic [15:0] w);
      ld_en   = 1'b1;
      ld_dmem = sel;
      ld_addr = a[15:0];
      ld_data = w;
      @(negedge clk);
      ld_en   = 1'b0;
   endtask

   task automatic emit(logic [15:0] w);
      put(1'b0, pa, w);
      pa++;
   endtask

   task automatic halt();
      emit(enc_j(O_J, 0));
   endtask

   task automatic go(int n);
      rst = 1'b0;
      repeat (n) @(negedge clk);
      #1;
   endtask

   localparam logic [15:0] VA = 16'hA503;
   localparam logic [15:0] VB = 16'h3BF9;

   task automatic load_ab();
      emit(enc_lui(1, 8'hA5));
      emit(enc_i(O_ADDI, 1, 1, 3));
      emit(enc_lui(2, 8'h3C));
      emit(enc_i(O_ADDI, 2, 2, -7));
   endtask

   task automatic t_reset();
      begin_test();
      put(1'b0, 0, enc_j(O_J, 5));
      put(1'b0, 5, enc_j(O_J, 0));
      @(negedge clk);
      chk("R1 pc held at zero in reset", pc_o, 16'h0000);
      chk("R1 no store in reset", {15'd0, st_en_o}, 16'h0000);
      go(1);
      chk("R1 first edge runs word 0", pc_o, 16'h0005);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 reset mid-run clears pc", pc_o, 16'h0000);
   endtask

   task automatic t_zero();
      begin_test();
      emit(enc_i(O_ADDI, 0, 0, 5));
      emit(enc_s(O_SW, 0, 0, 0));
      emit(enc_lui(1, 8'h12));
      emit(enc_r(O_RA, 1, 1, 0, 0));
      emit(enc_s(O_SW, 0, 0, 1));
      emit(enc_r(O_RA, 0, 1, 2, 0));
      emit(enc_s(O_SW, 0, 2, 2));
      halt();
      go(12);
      chk("R2 store count", 16'(lg_n), 16'd3);
      chk_st("R2 addi into r0 dropped", 0, 16'h0000, 16'h0000);
      chk_st("R2 add into r0 dropped", 1, 16'h0001, 16'h0000);
      chk_st("R2 r0 operand reads zero", 2, 16'h0002, 16'h1200);
      chk("R2 halt pc", pc_o, 16'(pa - 1));
   endtask

   task automatic t_arith();
      begin_test();
      load_ab();
      emit(enc_r(O_RA, 1, 2, 3, 0)); emit(enc_s(O_SW, 0, 3, 0));
      emit(enc_r(O_RA, 1, 2, 3, 1)); emit(enc_s(O_SW, 0, 3, 1));
      emit(enc_r(O_RA, 1, 2, 3, 2)); emit(enc_s(O_SW, 0, 3, 2));
      emit(enc_r(O_RA, 1, 2, 3, 3)); emit(enc_s(O_SW, 0, 3, 3));
      emit(enc_r(O_RB, 1, 2, 3, 0)); emit(enc_s(O_SW, 0, 3, 4));
      halt();
      go(20);
      chk("R3 store count", 16'(lg_n), 16'd5);
      chk_st("R3 add", 0, 16'd0, VA + VB);
      chk_st("R3 sub", 1, 16'd1, VA - VB);
      chk_st("R3 and", 2, 16'd2, VA & VB);
      chk_st("R3 or",  3, 16'd3, VA | VB);
      chk_st("R3 xor", 4, 16'd4, VA ^ VB);
   endtask

   task automatic t_shift();
      logic signed [15:0] sa;
      sa = VA;
      begin_test();
      load_ab();
      emit(enc_i(O_ADDI, 0, 4, 4));
      emit(enc_r(O_RB, 1, 4, 3, 1)); emit(enc_s(O_SW, 0, 3, 0));
      emit(enc_r(O_RB, 1, 4, 3, 2)); emit(enc_s(O_SW, 0, 3, 1));
      emit(enc_r(O_RB, 1, 4, 3, 3)); emit(enc_s(O_SW, 0, 3, 2));
      emit(enc_i(O_ADDI, 0, 4, 15));
      emit(enc_r(O_RB, 1, 4, 3, 3)); emit(enc_s(O_SW, 0, 3, 3));
      emit(enc_r(O_RB, 1, 4, 3, 2)); emit(enc_s(O_SW, 0, 3, 4));
      emit(enc_lui(4, 8'h01));
      emit(enc_r(O_RB, 1, 4, 3, 1)); emit(enc_s(O_SW, 0, 3, 5));
      halt();
      go(26);
      chk("R4 store count", 16'(lg_n), 16'd6);
      chk_st("R4 sll 4",  0, 16'd0, VA << 4);
      chk_st("R4 srl 4",  1, 16'd1, VA >> 4);
      chk_st("R4 sra 4",  2, 16'd2, 16'(sa >>> 4));
      chk_st("R4 sra 15", 3, 16'd3, 16'hFFFF);
      chk_st("R4 srl 15", 4, 16'd4, 16'h0001);
      chk_st("R4 amount uses low 4 bits", 5, 16'd5, VA);
   endtask

   task automatic t_compare();
      begin_test();
      load_ab();
      emit(enc_r(O_RC, 1, 2, 3, 0)); emit(enc_s(O_SW, 0, 3, 0));
      emit(enc_r(O_RC, 2, 1, 3, 0)); emit(enc_s(O_SW, 0, 3, 1));
      emit(enc_r(O_RC, 1, 2, 3, 1)); emit(enc_s(O_SW, 0, 3, 2));
      emit(enc_r(O_RC, 2, 1, 3, 1)); emit(enc_s(O_SW, 0, 3, 3));
      emit(enc_r(O_RC, 1, 1, 3, 0)); emit(enc_s(O_SW, 0, 3, 4));
      emit(enc_r(O_RC, 1, 2, 3, 2)); emit(enc_s(O_SW, 0, 3, 5));
      halt();
      go(24);
      chk_st("R5 slt neg<pos", 0, 16'd0, 16'd1);
      chk_st("R5 slt pos<neg", 1, 16'd1, 16'd0);
      chk_st("R5 sltu big<small", 2, 16'd2, 16'd0);
      chk_st("R5 sltu small<big", 3, 16'd3, 16'd1);
      chk_st("R5 slt equal", 4, 16'd4, 16'd0);
      chk_st("R5 reserved subfunction keeps rd", 5, 16'd5, 16'd0);
   endtask

   task automatic t_imm();
      logic signed [15:0] sa;
      sa = VA;
      begin_test();
      emit(enc_lui(1, 8'hA5));
      emit(enc_i(O_ADDI, 1, 1, 3));
      emit(enc_i(O_ADDI, 0, 5, -16)); emit(enc_s(O_SW, 0, 5, 0));
      emit(enc_i(O_ADDI, 0, 5, 15));  emit(enc_s(O_SW, 0, 5, 1));
      emit(enc_i(O_ANDI, 1, 5, -2));  emit(enc_s(O_SW, 0, 5, 2));
      emit(enc_i(O_ORI,  1, 5, -8));  emit(enc_s(O_SW, 0, 5, 3));
      emit(enc_i(O_XORI, 1, 5, -1));  emit(enc_s(O_SW, 0, 5, 4));
      emit(enc_i(O_SLTI, 1, 5, 0));   emit(enc_s(O_SW, 0, 5, 5));
      emit(enc_i(O_SLLI, 1, 5, 4));   emit(enc_s(O_SW, 0, 5, 6));
      emit(enc_i(O_SRLI, 1, 5, 4));   emit(enc_s(O_SW, 0, 5, 7));
      emit(enc_i(O_SRAI, 1, 5, 4));   emit(enc_s(O_SW, 0, 5, 8));
      halt();
      go(26);
      chk("R6 store count", 16'(lg_n), 16'd9);
      chk_st("R6 addi -16", 0, 16'd0, 16'hFFF0);
      chk_st("R6 addi 15",  1, 16'd1, 16'h000F);
      chk_st("R6 andi",     2, 16'd2, VA & 16'hFFFE);
      chk_st("R6 ori",      3, 16'd3, VA | 16'hFFF8);
      chk_st("R6 xori",     4, 16'd4, ~VA);
      chk_st("R6 slti",     5, 16'd5, 16'd1);
      chk_st("R6 slli",     6, 16'd6, VA << 4);
      chk_st("R6 srli",     7, 16'd7, VA >> 4);
      chk_st("R6 srai",     8, 16'd8, 16'(sa >>> 4));
   endtask

   task automatic t_lui();
      begin_test();
      emit(enc_lui(5, 8'hFF)); emit(enc_s(O_SW, 0, 5, 0));
      emit(enc_lui(5, 8'h81)); emit(enc_s(O_SW, 0, 5, 1));
      halt();
      go(8);
      chk_st("R7 lui ff", 0, 16'd0, 16'hFF00);
      chk_st("R7 lui 81", 1, 16'd1, 16'h8100);
   endtask

   task automatic t_mem();
      begin_test();
      put(1'b1, 10, 16'h1234);
      emit(enc_i(O_ADDI, 0, 1, 12));
      emit(enc_i(O_LW, 1, 2, -2));
      emit(enc_s(O_SW, 1, 2, 3));
      emit(enc_i(O_ADDI, 0, 6, 0));
      emit(enc_i(O_ADDI, 6, 6, -1));
      emit(enc_s(O_SW, 6, 1, 0));
      emit(enc_i(O_ADDI, 6, 6, -1));
      emit(enc_s(O_SW, 6, 2, 0));
      emit(enc_i(O_LW, 6, 3, 1));
      emit(enc_s(O_SW, 0, 3, 5));
      halt();
      go(16);
      chk("R8 store count", 16'(lg_n), 16'd4);
      chk_st("R8 load then store displaced", 0, 16'd15, 16'h1234);
      chk_st("R8 push at sp below zero", 1, 16'hFFFF, 16'h000C);
      chk_st("R8 second push lower", 2, 16'hFFFE, 16'h1234);
      chk_st("R8 reload from stack", 3, 16'd5, 16'h000C);
   endtask

   task automatic t_branch();
      begin_test();
      emit(enc_i(O_ADDI, 0, 1, 3));
      emit(enc_i(O_ADDI, 0, 2, 3));
      emit(enc_s(O_BEQ, 1, 2, 3));
      emit(enc_s(O_SW, 0, 1, 7));
      emit(enc_s(O_SW, 0, 1, 7));
      emit(enc_s(O_BNE, 1, 2, 2));
      emit(enc_s(O_SW, 0, 2, 1));
      emit(enc_i(O_ADDI, 0, 3, 0));
      emit(enc_i(O_ADDI, 3, 3, 1));
      emit(enc_s(O_BNE, 3, 1, -1));
      emit(enc_s(O_SW, 0, 3, 2));
      emit(enc_s(O_BEQ, 3, 0, 2));
      halt();
      go(30);
      chk("R9 store count", 16'(lg_n), 16'd2);
      chk_st("R9 taken beq skips, untaken bne falls", 0, 16'd1, 16'd3);
      chk_st("R9 backward loop count", 1, 16'd2, 16'd3);
      chk("R9 final pc", pc_o, 16'd12);
   endtask

   task automatic t_jump();
      begin_test();
      emit(enc_j(O_J, 3));
      emit(enc_s(O_SW, 0, 0, 9));
      emit(enc_s(O_SW, 0, 0, 9));
      emit(enc_j(O_JAL, 3));
      emit(enc_s(O_SW, 0, 0, 9));
      emit(enc_s(O_SW, 0, 0, 9));
      emit(enc_s(O_SW, 0, 7, 0));
      emit(enc_j(O_J, 4));
      emit(enc_s(O_SW, 0, 0, 2));
      emit(enc_j(O_J, 3));
      emit(enc_s(O_SW, 0, 0, 9));
      emit(enc_j(O_J, -3));
      halt();
      go(16);
      chk("R10 store count", 16'(lg_n), 16'd2);
      chk_st("R10 jal links pc+1 in r7", 0, 16'd0, 16'd4);
      chk_st("R10 backward jump target", 1, 16'd2, 16'd0);
      chk("R10 final pc", pc_o, 16'd12);
   endtask

   task automatic t_jalr();
      begin_test();
      emit(enc_i(O_ADDI, 0, 4, 5));
      emit(enc_i(O_JALR, 4, 5, 2));
      for (int k = 2; k < 7; k++) emit(enc_s(O_SW, 0, 0, 9));
      emit(enc_s(O_SW, 0, 5, 0));
      emit(enc_i(O_ADDI, 0, 4, 15));
      emit(enc_i(O_JALR, 4, 4, -3));
      emit(enc_s(O_SW, 0, 0, 9));
      emit(enc_s(O_SW, 0, 0, 9));
      emit(enc_s(O_SW, 0, 4, 1));
      halt();
      go(14);
      chk("R11 store count", 16'(lg_n), 16'd2);
      chk_st("R11 jalr link in named rd", 0, 16'd0, 16'd2);
      chk_st("R11 target from old rs1, link in same reg", 1, 16'd1, 16'd10);
      chk("R11 final pc", pc_o, 16'd13);
   endtask

   task automatic t_unused();
      begin_test();
      emit(enc_lui(1, 8'h12));
      emit(enc_i(31, 1, 1, 5));
      emit(enc_i(19, 1, 1, 5));
      emit(enc_s(24, 1, 1, 5));
      emit(enc_s(O_SW, 0, 1, 0));
      halt();
      go(4);
      chk("R12 pc steps over unused opcodes", pc_o, 16'd4);
      go(4);
      chk("R12 store count", 16'(lg_n), 16'd1);
      chk_st("R12 register untouched", 0, 16'd0, 16'h1200);
   endtask

   initial begin
      #(100000 * 5);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_zero();
      t_arith();
      t_shift();
      t_compare();
      t_imm();
      t_lui();
      t_mem();
      t_branch();
      t_jump();
      t_jalr();
      t_unused();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule